// File: doc/BRIEF.md
# Dual-Port GPIO Controller

This block is a register-controlled general-purpose I/O unit for two 8-bit ports, called port A and port B. Software writes output latches, direction registers and one shared pull-down control register through a small synchronous register port. The block drives pad-side output, output-enable and pull-down-enable signals for each pin. A read of a port address returns a per-pin merge: input pins show a synchronized copy of the pad, and output pins show their latch.

Only the low nibble of port A exists. Pin 3 of port B can only be an input. The pull-down controls are active-low and reach only pins 0..2 of each port. Port B also has a change detector. It emits a one-clock pulse whenever any of its synchronized inputs differs from the previous sample, and wake-up or interrupt logic elsewhere can use that pulse.

Top module: `gpio_dual_port`

## Requirements
- R1: After reset, port A direction reads 0x0F, port B direction reads 0xFF, pull-down control reads 0x77, both data latches are 0, every output enable is 0 and every pull-down enable is 0.
- R2: A direction bit of 0 makes the pin an output (output enable 1, pad output equals the latch bit). A direction bit of 1 makes it an input (output enable 0). Register writes take effect on the clock edge where write strobe is high.
- R3: Port A bits 7..4 do not exist. Writes to them are ignored. Its data and direction reads return 0 there, and its output enables and pad outputs for those bits stay 0.
- R4: Port B pin 3 is input-only. Its output enable and pad output are always 0, and a read of port B data always returns the synchronized pad value in bit 3, whatever the direction bit holds.
- R5: The pull-down control is active-low. Bits 2..0 control port A pins 2..0, and bits 6..4 control port B pins 2..0. A bit of 0 drives the matching pull-down enable to 1. Bits 3 and 7 are ignored and read 0, and pull-down enables for pins 3..7 are always 0.
- R6: A read of address 0 (port A) or 1 (port B) returns, for each pin, the pad value through a two-flop synchronizer if the pin is an input, and the latch if the pin is an output. A pad change becomes visible after the second rising clock edge that follows it.
- R7: Any change on one or more port B pad inputs produces exactly one clock cycle of change pulse, starting after the second rising edge following the change. Stable inputs produce no pulse.
- R8: The direction registers (address 2 for A, 3 for B) and the pull-down control (address 4) read back what was written, masked to their implemented bits. Reads are combinational from the address.
- R9: Addresses 5..7 read 0, and writes to them change no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for bus_addr |
| pad_in_a | input | 8 | Port A pad inputs |
| pad_in_b | input | 8 | Port B pad inputs |
| pad_out_a | output | 8 | Port A pad output values |
| pad_oe_a | output | 8 | Port A output enables |
| pad_out_b | output | 8 | Port B pad output values |
| pad_oe_b | output | 8 | Port B output enables |
| pad_pd_a | output | 8 | Port A pull-down enables, active-high |
| pad_pd_b | output | 8 | Port B pull-down enables, active-high |
| chg_pulse | output | 1 | Port B input change pulse |

## Verification
Register writes show at the pad outputs, and in read-back, right after the single clock edge that captures them. The bench therefore checks them at the following falling edge. Pad-to-read-back and pad-to-pulse paths pass through two synchronizer flops. The bench changes a pad at a falling edge and samples at the next three falling edges: the pulse must read 0, then 1, then 0, and the read-back must show the new value from the second one. Reads are combinational, so the bench sets the address at a falling edge and samples shortly after.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int DATA_W       = 8;
    localparam int ADDR_W       = 3;
    localparam int A_PINS       = 4;
    localparam int B_INONLY_PIN = 3;
    localparam int PD_FIELD_W   = 3;
    localparam int PD_A_LSB     = 0;
    localparam int PD_B_LSB     = 4;

    typedef logic [DATA_W-1:0] word_t;

    localparam word_t A_MASK        = word_t'((1 << A_PINS) - 1);
    localparam word_t B_MASK        = '1;
    localparam word_t B_INONLY_MASK = word_t'(1 << B_INONLY_PIN);
    localparam word_t NO_INONLY     = '0;
    localparam word_t PD_FIELD      = word_t'((1 << PD_FIELD_W) - 1);
    localparam word_t PD_MASK       = (PD_FIELD << PD_A_LSB) | (PD_FIELD << PD_B_LSB);

    typedef enum logic [ADDR_W-1:0] {
        REG_A_DATA = 3'd0,
        REG_B_DATA = 3'd1,
        REG_A_DIR  = 3'd2,
        REG_B_DIR  = 3'd3,
        REG_PD_CTL = 3'd4
    } reg_addr_e;

    typedef struct packed {
        word_t latch;
        word_t dir;
    } port_cfg_t;

    typedef struct packed {
        word_t dout;
        word_t oe;
    } pad_drive_t;

    // Pad drive from a port's configuration; unimplemented and input-only pins stay quiet.
    function automatic pad_drive_t drive_of(port_cfg_t c, word_t impl, word_t inonly);
        pad_drive_t d;
        d.oe   = ~c.dir & impl & ~inonly;
        d.dout = c.latch & impl & ~inonly;
        return d;
    endfunction

    // Active-low control field starting at lsb turned into active-high enables on pins 0..
    function automatic word_t pd_lanes(word_t ctl_n, int lsb);
        word_t r;
        r = '0;
        for (int i = 0; i < PD_FIELD_W; i++) begin
            r[i] = ~ctl_n[lsb + i];
        end
        return r;
    endfunction

    // Per-pin read-back: synchronized pad for inputs, latch for outputs.
    function automatic word_t merge_read(port_cfg_t c, word_t pads, word_t impl, word_t inonly);
        word_t from_pad;
        from_pad = c.dir | inonly;
        return ((pads & from_pad) | (c.latch & ~from_pad)) & impl;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_change_det.sv
module gpio_change_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sampled,
    output logic         pulse
);

    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= sampled;
    end

    assign pulse = |(sampled ^ prev);

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    output port_cfg_t         cfg_a,
    output port_cfg_t         cfg_b,
    output word_t             pd_ctl_n
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_a.latch <= '0;
            cfg_a.dir   <= A_MASK;
            cfg_b.latch <= '0;
            cfg_b.dir   <= B_MASK;
            pd_ctl_n    <= PD_MASK;
        end else if (we) begin
            case (addr)
                REG_A_DATA: cfg_a.latch <= wdata & A_MASK;
                REG_B_DATA: cfg_b.latch <= wdata & B_MASK;
                REG_A_DIR:  cfg_a.dir   <= wdata & A_MASK;
                REG_B_DIR:  cfg_b.dir   <= wdata & B_MASK;
                REG_PD_CTL: pd_ctl_n    <= wdata & PD_MASK;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux
    import gpio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  port_cfg_t         cfg_a,
    input  port_cfg_t         cfg_b,
    input  word_t             pd_ctl_n,
    input  word_t             sync_a,
    input  word_t             sync_b,
    output word_t             rdata
);

    always_comb begin
        case (addr)
            REG_A_DATA: rdata = merge_read(cfg_a, sync_a, A_MASK, NO_INONLY);
            REG_B_DATA: rdata = merge_read(cfg_b, sync_b, B_MASK, B_INONLY_MASK);
            REG_A_DIR:  rdata = cfg_a.dir;
            REG_B_DIR:  rdata = cfg_b.dir;
            REG_PD_CTL: rdata = pd_ctl_n;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_dual_port.sv
module gpio_dual_port
    import gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pad_in_a,
    input  logic [DATA_W-1:0] pad_in_b,
    output logic [DATA_W-1:0] pad_out_a,
    output logic [DATA_W-1:0] pad_oe_a,
    output logic [DATA_W-1:0] pad_out_b,
    output logic [DATA_W-1:0] pad_oe_b,
    output logic [DATA_W-1:0] pad_pd_a,
    output logic [DATA_W-1:0] pad_pd_b,
    output logic              chg_pulse
);

    port_cfg_t  cfg_a, cfg_b;
    word_t      pd_ctl_n;
    word_t      sync_a, sync_b;
    pad_drive_t drv_a, drv_b;

    gpio_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cfg_a    (cfg_a),
        .cfg_b    (cfg_b),
        .pd_ctl_n (pd_ctl_n)
    );

    gpio_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync_a (
        .clk (clk),
        .rst (rst),
        .d   (pad_in_a),
        .q   (sync_a)
    );

    gpio_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync_b (
        .clk (clk),
        .rst (rst),
        .d   (pad_in_b),
        .q   (sync_b)
    );

    gpio_change_det #(.W(DATA_W)) u_chg (
        .clk     (clk),
        .rst     (rst),
        .sampled (sync_b),
        .pulse   (chg_pulse)
    );

    gpio_readmux u_rd (
        .addr     (bus_addr),
        .cfg_a    (cfg_a),
        .cfg_b    (cfg_b),
        .pd_ctl_n (pd_ctl_n),
        .sync_a   (sync_a),
        .sync_b   (sync_b),
        .rdata    (bus_rdata)
    );

    assign drv_a     = drive_of(cfg_a, A_MASK, NO_INONLY);
    assign drv_b     = drive_of(cfg_b, B_MASK, B_INONLY_MASK);
    assign pad_out_a = drv_a.dout;
    assign pad_oe_a  = drv_a.oe;
    assign pad_out_b = drv_b.dout;
    assign pad_oe_b  = drv_b.oe;
    assign pad_pd_a  = pd_lanes(pd_ctl_n, PD_A_LSB);
    assign pad_pd_b  = pd_lanes(pd_ctl_n, PD_B_LSB);

endmodule

// File: rtl/gpio_dual_port_chk.sv
module gpio_dual_port_chk
    import gpio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic [DATA_W-1:0] pad_in_b,
    input logic [DATA_W-1:0] pad_out_a,
    input logic [DATA_W-1:0] pad_oe_a,
    input logic [DATA_W-1:0] pad_out_b,
    input logic [DATA_W-1:0] pad_oe_b,
    input logic [DATA_W-1:0] pad_pd_a,
    input logic [DATA_W-1:0] pad_pd_b,
    input logic              chg_pulse
);

    logic [2:0] run_cyc;

    always_ff @(posedge clk) begin
        if (rst)              run_cyc <= '0;
        else if (run_cyc != 3'd7) run_cyc <= run_cyc + 3'd1;
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe_a == '0 && pad_oe_b == '0 && pad_pd_a == '0 && pad_pd_b == '0));

    // R2
    a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == REG_B_DIR) |=> (pad_oe_b == (~$past(bus_wdata) & ~B_INONLY_MASK)));

    // R3
    a_r3_upper_a_quiet: assert property (@(posedge clk) disable iff (rst)
        (pad_oe_a[7:4] == 4'h0 && pad_out_a[7:4] == 4'h0));

    // R3
    a_r3_latch_a_masked: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == REG_A_DATA) |=> (pad_out_a == ($past(bus_wdata) & A_MASK)));

    // R4
    a_r4_pin3_never_driven: assert property (@(posedge clk) disable iff (rst)
        (!pad_oe_b[B_INONLY_PIN] && !pad_out_b[B_INONLY_PIN]));

    // R5
    a_r5_pd_map: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == REG_PD_CTL) |=>
        (pad_pd_a == {5'b0, ~$past(bus_wdata[2:0])} && pad_pd_b == {5'b0, ~$past(bus_wdata[6:4])}));

    // R7
    a_r7_change_pulses: assert property (@(posedge clk) disable iff (rst)
        (run_cyc >= 3'd1 && pad_in_b != $past(pad_in_b)) |-> ##2 chg_pulse);

    // R7
    a_r7_pulse_has_cause: assert property (@(posedge clk) disable iff (rst)
        (run_cyc >= 3'd4 && chg_pulse) |-> ($past(pad_in_b, 2) != $past(pad_in_b, 3)));

    // R9
    a_r9_unmapped_no_effect: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr > REG_PD_CTL) |=> ($stable(pad_oe_a) && $stable(pad_oe_b) &&
        $stable(pad_out_a) && $stable(pad_out_b) && $stable(pad_pd_a) && $stable(pad_pd_b)));

endmodule

bind gpio_dual_port gpio_dual_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .pad_in_b  (pad_in_b),
    .pad_out_a (pad_out_a),
    .pad_oe_a  (pad_oe_a),
    .pad_out_b (pad_out_b),
    .pad_oe_b  (pad_oe_b),
    .pad_pd_a  (pad_pd_a),
    .pad_pd_b  (pad_pd_b),
    .chg_pulse (chg_pulse)
);

// File: tb/tb_gpio_dual_port.sv
`timescale 1ns/1ps
module tb_gpio_dual_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in_a = '0;
    logic [7:0] pad_in_b = '0;
    logic [7:0] pad_out_a, pad_oe_a, pad_out_b, pad_oe_b, pad_pd_a, pad_pd_b;
    logic       chg_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    gpio_dual_port dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pad_in_a  (pad_in_a),
        .pad_in_b  (pad_in_b),
        .pad_out_a (pad_out_a),
        .pad_oe_a  (pad_oe_a),
        .pad_out_b (pad_out_b),
        .pad_oe_b  (pad_oe_b),
        .pad_pd_a  (pad_pd_a),
        .pad_pd_b  (pad_pd_b),
        .chg_pulse (chg_pulse)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(3'd2, v); check("R1 A dir reset", v, 8'h0F);
        rd(3'd3, v); check("R1 B dir reset", v, 8'hFF);
        rd(3'd4, v); check("R1 pd reset", v, 8'h77);
        rd(3'd0, v); check("R1 A data reset", v, 8'h00);
        check("R1 oe A", pad_oe_a, 8'h00);
        check("R1 oe B", pad_oe_b, 8'h00);
        check("R1 pd A", pad_pd_a, 8'h00);
        check("R1 pd B", pad_pd_b, 8'h00);
        check("R1 out B", pad_out_b, 8'h00);
    endtask

    task automatic t_dir_and_out();
        wr(3'd1, 8'hA5);
        check("R2 out while input", pad_oe_b, 8'h00);
        wr(3'd3, 8'h0F);
        check("R2 oe B", pad_oe_b, 8'hF0);
        check("R2 out B", pad_out_b, 8'hA5);
        wr(3'd3, 8'h00);
        check("R4 oe B pin3 held", pad_oe_b, 8'hF7);
        check("R4 out B pin3 held", pad_out_b, 8'hA5);
        wr(3'd1, 8'hFF);
        check("R4 out B all ones", pad_out_b, 8'hF7);
    endtask

    task automatic t_nibble();
        logic [7:0] v;
        wr(3'd2, 8'hF0);
        rd(3'd2, v); check("R3 A dir upper ignored", v, 8'h00);
        check("R3 oe A", pad_oe_a, 8'h0F);
        wr(3'd0, 8'hFF);
        check("R3 out A", pad_out_a, 8'h0F);
        rd(3'd0, v); check("R3 A data read", v, 8'h0F);
        wr(3'd2, 8'hFF);
        rd(3'd2, v); check("R8 A dir read", v, 8'h0F);
        check("R2 oe A inputs", pad_oe_a, 8'h00);
    endtask

    task automatic t_readback();
        logic [7:0] v;
        wr(3'd2, 8'h03);
        pad_in_a = 8'hF1;
        tick(1);
        rd(3'd0, v); check("R6 A before sync", v, 8'h0C);
        tick(1);
        rd(3'd0, v); check("R6 A merged", v, 8'h0D);
        // B: all outputs with latch 0xFF, pin 3 follows pad
        pad_in_b = 8'h00;
        tick(3);
        rd(3'd1, v); check("R4 B pin3 pad 0", v, 8'hF7);
        pad_in_b = 8'h08;
        tick(2);
        rd(3'd1, v); check("R4 B pin3 pad 1", v, 8'hFF);
        wr(3'd3, 8'hFF);
        wr(3'd1, 8'h00);
        pad_in_b = 8'h3C;
        tick(2);
        rd(3'd1, v); check("R6 B all inputs", v, 8'h3C);
        tick(2);
    endtask

    task automatic t_pulldown();
        logic [7:0] v;
        wr(3'd4, 8'h00);
        check("R5 pd A all on", pad_pd_a, 8'h07);
        check("R5 pd B all on", pad_pd_b, 8'h07);
        rd(3'd4, v); check("R5 pd read zero", v, 8'h00);
        wr(3'd4, 8'h5A);
        check("R5 pd A map", pad_pd_a, 8'h05);
        check("R5 pd B map", pad_pd_b, 8'h02);
        rd(3'd4, v); check("R8 pd read masked", v, 8'h52);
        wr(3'd4, 8'h88);
        check("R5 pd unused bits A", pad_pd_a, 8'h07);
        check("R5 pd unused bits B", pad_pd_b, 8'h07);
    endtask

    task automatic t_change();
        tick(3);
        check("R7 idle no pulse", {7'b0, chg_pulse}, 8'h00);
        pad_in_b = pad_in_b ^ 8'h80;
        tick(1); check("R7 pulse after 1", {7'b0, chg_pulse}, 8'h00);
        tick(1); check("R7 pulse after 2", {7'b0, chg_pulse}, 8'h01);
        tick(1); check("R7 pulse ends", {7'b0, chg_pulse}, 8'h00);
        pad_in_b = pad_in_b ^ 8'h09;
        tick(1); check("R7 multi after 1", {7'b0, chg_pulse}, 8'h00);
        tick(1); check("R7 multi after 2", {7'b0, chg_pulse}, 8'h01);
        tick(1); check("R7 multi ends", {7'b0, chg_pulse}, 8'h00);
        tick(4); check("R7 stable stays low", {7'b0, chg_pulse}, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        logic [7:0] oe_b0, pd_b0, out_a0;
        oe_b0 = pad_oe_b; pd_b0 = pad_pd_b; out_a0 = pad_out_a;
        wr(3'd5, 8'h00);
        wr(3'd7, 8'h00);
        rd(3'd7, v); check("R9 unmapped read", v, 8'h00);
        rd(3'd6, v); check("R9 unmapped read 6", v, 8'h00);
        check("R9 oe B unchanged", pad_oe_b, oe_b0);
        check("R9 pd B unchanged", pad_pd_b, pd_b0);
        check("R9 out A unchanged", pad_out_a, out_a0);
        rd(3'd3, v); check("R9 B dir unchanged", v, 8'hFF);
        rd(3'd4, v); check("R9 pd unchanged", v, 8'h00);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0x01 expected 0x00");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_dir_and_out();
        t_nibble();
        t_readback();
        t_pulldown();
        t_change();
        t_unmapped();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule